// File: doc/BRIEF.md
# Operation Sampling Interval Selector

This block picks individual operations out of a stream for detailed profiling. Each cycle in which `popPulse` is high marks one eligible operation. A down-counter counts these operations against a programmable interval, and when the interval runs out the block raises `selStrobe` in the same cycle as that operation's pulse. Optional pseudo-random jitter lengthens each automatic reload, so the selection points do not lock onto the period of a program loop.

Only one selected operation may be outstanding. The selection sets an in-flight flag, and only `doneIn` clears it. If the interval expires while the flag is set, the block drops that selection, issues no strobe and increments a saturating collision counter. Software configures the block through a small register port. When the interval register is zero, a built-in minimum interval applies, and that minimum can be read back as a capability value.

Top module: `opSampler`

## Requirements
- R1: With a non-zero interval N programmed at address 0 (bits 23:0), `selStrobe` rises on every Nth `popPulse` cycle, counted from the last reload, whenever no operation is in flight. It is high only in cycles where `popPulse` is high.
- R2: When the interval register holds 0, the interval in force is `MIN_INTERVAL`. A read of address 2 returns `MIN_INTERVAL`, and writes to address 2 are ignored.
- R3: When control bit 0 (address 1) is set, every reload caused by expiry adds the low 8 bits of a 16-bit LFSR to the interval. The LFSR starts at 0xACE1. After each such reload it shifts left and takes in bit15^bit13^bit12^bit10 as its new bit 0. The first period after an interval write carries no jitter.
- R4: A strobe sets the in-flight state. No further strobe is issued until `doneIn` has been seen.
- R5: An expiry while an operation is in flight and `doneIn` is low is a collision. It gives no strobe, increments `collCount`, and the counter still reloads.
- R6: `collCount` saturates at all-ones. `clrColl` sets it to zero on the next edge and overrides a collision in the same cycle.
- R7: An expiry in the same cycle as `doneIn` produces a strobe and is not a collision.
- R8: A write to address 0 reloads the counter with the new effective interval without jitter. A `popPulse` in that cycle is ignored. Addresses 0 and 1 read back what was written, and address 3 reads 0.
- R9: After reset the interval and control registers read 0, `collCount` is 0, and the first strobe falls on the `MIN_INTERVAL`-th pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write enable |
| cfgAddr | input | 2 | Register address (0 interval, 1 control, 2 capability, 3 reserved) |
| cfgWdata | input | 32 | Register write data |
| cfgRdata | output | 32 | Register read data for `cfgAddr` (combinational) |
| popPulse | input | 1 | One eligible operation this cycle |
| doneIn | input | 1 | The in-flight sampled operation has completed |
| clrColl | input | 1 | Clear the collision counter |
| selStrobe | output | 1 | Sample the operation marked by `popPulse` in this cycle |
| collCount | output | COLL_W | Saturating collision count |

## Verification
Two functions can fall in the same cycle: the interval expiring and `doneIn` releasing the slot. The bench first occupies the slot. It then drives the expiring pulse together with `doneIn` and requires a strobe with no change to `collCount`. A second pair is a collision landing on a `clrColl` cycle; it is provoked with a saturated counter and judged by `collCount` reading zero afterwards.

// File: rtl/opSamplerPkg.sv
package opSamplerPkg;
  localparam logic [1:0] ADDR_INTERVAL = 2'd0;
  localparam logic [1:0] ADDR_CTRL     = 2'd1;
  localparam logic [1:0] ADDR_CAP      = 2'd2;

  typedef struct packed {
    logic cfgLoad;    // interval written: plain reload
    logic decr;       // counted operation, no expiry
    logic expReload;  // expiry: reload with optional jitter
    logic collInc;    // dropped selection
    logic collClr;    // clear collision count
  } ctrlStrobes_t;
endpackage

// File: rtl/opSamplerDp.sv
module opSamplerDp
  import opSamplerPkg::*;
#(
  parameter int CNT_W        = 24,
  parameter int COLL_W       = 32,
  parameter int DATA_W       = 32,
  parameter int MIN_INTERVAL = 256,
  parameter int JIT_W        = 8,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  parameter logic [15:0] LFSR_TAPS = 16'hB400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  input  ctrlStrobes_t      stb,
  output logic              expireNow,
  output logic [DATA_W-1:0] cfgRdata,
  output logic [COLL_W-1:0] collCount
);
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_INTERVAL);

  logic [CNT_W-1:0]  intervalQ, cntQ, effInterval, effNew, jitReload;
  logic [CNT_W:0]    jitSum;
  logic              jitEnQ;
  logic [15:0]       lfsrQ, lfsrNext;
  logic [COLL_W-1:0] collQ;
  logic              unusedWdata;

  assign unusedWdata = ^cfgWdata[DATA_W-1:CNT_W];

  assign effInterval = (intervalQ == '0) ? MIN_CNT : intervalQ;
  assign effNew      = (cfgWdata[CNT_W-1:0] == '0) ? MIN_CNT : cfgWdata[CNT_W-1:0];
  assign jitSum      = {1'b0, effInterval}
                     + (CNT_W+1)'(jitEnQ ? lfsrQ[JIT_W-1:0] : '0);
  assign jitReload   = jitSum[CNT_W] ? '1 : jitSum[CNT_W-1:0];
  assign lfsrNext    = {lfsrQ[14:0], ^(lfsrQ & LFSR_TAPS)};
  assign expireNow   = (cntQ <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intervalQ <= '0;
      jitEnQ    <= 1'b0;
      cntQ      <= MIN_CNT;
      lfsrQ     <= LFSR_SEED;
    end else begin
      if (cfgWe && cfgAddr == ADDR_INTERVAL) intervalQ <= cfgWdata[CNT_W-1:0];
      if (cfgWe && cfgAddr == ADDR_CTRL)     jitEnQ    <= cfgWdata[0];
      if (stb.cfgLoad)        cntQ <= effNew;
      else if (stb.expReload) cntQ <= jitReload;
      else if (stb.decr)      cntQ <= cntQ - CNT_W'(1);
      if (stb.expReload && jitEnQ) lfsrQ <= lfsrNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.collClr)             collQ <= '0;
    else if (stb.collInc && collQ != '1)  collQ <= collQ + COLL_W'(1);
  end

  assign collCount = collQ;

  always_comb begin
    unique case (cfgAddr)
      ADDR_INTERVAL: cfgRdata = DATA_W'(intervalQ);
      ADDR_CTRL:     cfgRdata = DATA_W'(jitEnQ);
      ADDR_CAP:      cfgRdata = DATA_W'(MIN_CNT);
      default:       cfgRdata = '0;
    endcase
  end
endmodule

// File: rtl/opSamplerCtrl.sv
module opSamplerCtrl
  import opSamplerPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         popPulse,
  input  logic         doneIn,
  input  logic         clrColl,
  input  logic         cfgWe,
  input  logic [1:0]   cfgAddr,
  input  logic         expireNow,
  output ctrlStrobes_t stb,
  output logic         selStrobe,
  output logic         inFlight
);
  logic busyQ, wrInterval, popEff, expire, slotFree;

  assign wrInterval = cfgWe && (cfgAddr == ADDR_INTERVAL);
  assign popEff     = popPulse && !wrInterval;
  assign expire     = popEff && expireNow;
  assign slotFree   = !busyQ || doneIn;
  assign selStrobe  = expire && slotFree;

  always_comb begin
    stb.cfgLoad   = wrInterval;
    stb.decr      = popEff && !expireNow;
    stb.expReload = expire;
    stb.collInc   = expire && !slotFree;
    stb.collClr   = clrColl;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          busyQ <= 1'b0;
    else if (selStrobe) busyQ <= 1'b1;
    else if (doneIn)    busyQ <= 1'b0;
  end

  assign inFlight = busyQ;
endmodule

// File: rtl/opSampler.sv
module opSampler
  import opSamplerPkg::*;
#(
  parameter int CNT_W        = 24,
  parameter int COLL_W       = 32,
  parameter int MIN_INTERVAL = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgRdata,
  input  logic              popPulse,
  input  logic              doneIn,
  input  logic              clrColl,
  output logic              selStrobe,
  output logic [COLL_W-1:0] collCount
);
  ctrlStrobes_t stb;
  logic         expireNow;
  logic         inFlight;

  opSamplerCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .popPulse(popPulse), .doneIn(doneIn),
    .clrColl(clrColl), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .expireNow(expireNow), .stb(stb), .selStrobe(selStrobe),
    .inFlight(inFlight)
  );

  opSamplerDp #(
    .CNT_W(CNT_W), .COLL_W(COLL_W), .DATA_W(32), .MIN_INTERVAL(MIN_INTERVAL)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .stb(stb), .expireNow(expireNow),
    .cfgRdata(cfgRdata), .collCount(collCount)
  );
endmodule

// File: rtl/opSamplerChk.sv
module opSamplerChk #(
  parameter int COLL_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              popPulse,
  input logic              doneIn,
  input logic              clrColl,
  input logic              selStrobe,
  input logic              inFlight,
  input logic              collInc,
  input logic [COLL_W-1:0] collCount
);
  // R1: a strobe only marks a real operation
  a_r1_sel_with_pop: assert property (@(posedge clk) disable iff (!rstN)
    selStrobe |-> popPulse);

  // R4: a strobe leaves an operation in flight
  a_r4_busy_after_sel: assert property (@(posedge clk) disable iff (!rstN)
    selStrobe |=> inFlight);

  // R4: in flight without completion blocks a strobe
  a_r4_one_in_flight: assert property (@(posedge clk) disable iff (!rstN)
    (inFlight && !doneIn) |-> !selStrobe);

  // R4: only completion releases the slot
  a_r4_hold_busy: assert property (@(posedge clk) disable iff (!rstN)
    (inFlight && !doneIn) |=> inFlight);

  // R5: a collision advances the count by one
  a_r5_coll_count: assert property (@(posedge clk) disable iff (!rstN)
    (collInc && !clrColl && collCount != '1) |=> collCount == $past(collCount) + COLL_W'(1));

  // R5: a collision never coincides with a strobe
  a_r5_coll_no_sel: assert property (@(posedge clk) disable iff (!rstN)
    collInc |-> !selStrobe);

  // R6: clear wins
  a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
    clrColl |=> collCount == '0);

  // R6: no wrap at saturation
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (collCount == '1 && !clrColl) |=> collCount == '1);
endmodule

bind opSampler opSamplerChk #(.COLL_W(COLL_W)) chk_i (
  .clk(clk), .rstN(rstN), .popPulse(popPulse), .doneIn(doneIn),
  .clrColl(clrColl), .selStrobe(selStrobe), .inFlight(inFlight),
  .collInc(stb.collInc), .collCount(collCount)
);

// File: tb/opSampler_tb_top.sv
module opSampler_tb_top;
  localparam int MIN_IV  = 8;
  localparam int COLL_W  = 4;
  localparam int NVEC    = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgAddr = 2'd0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic popPulse = 1'b0, doneIn = 1'b0, clrColl = 1'b0;
  logic selStrobe;
  logic [COLL_W-1:0] collCount;

  int runCnt = 0;
  int failCnt = 0;
  logic lastSel;

  always #10 clk = ~clk;

  opSampler #(.CNT_W(24), .COLL_W(COLL_W), .MIN_INTERVAL(MIN_IV)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .popPulse(popPulse),
    .doneIn(doneIn), .clrColl(clrColl), .selStrobe(selStrobe),
    .collCount(collCount)
  );

  // interval, pops, expected strobes, expected index of first strobe
  typedef struct packed {
    logic [31:0] iv;
    logic [31:0] pops;
    logic [31:0] sels;
    logic [31:0] first;
  } vec_t;
  localparam vec_t VECS [NVEC] = '{
    '{32'd3, 32'd9,  32'd3, 32'd3},
    '{32'd5, 32'd12, 32'd2, 32'd5},
    '{32'd1, 32'd4,  32'd4, 32'd1},
    '{32'd0, 32'd17, 32'd2, 32'd8},
    '{32'd7, 32'd6,  32'd0, 32'd0}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    runCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsrStep(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic cyc(input logic pop, input logic done, input logic clr);
    @(negedge clk);
    cfgWe = 1'b0; popPulse = pop; doneIn = done; clrColl = clr;
    #1 lastSel = selStrobe;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 1'b0);
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d, input logic pop);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d; popPulse = pop; doneIn = 1'b0; clrColl = 1'b0;
    #1 lastSel = selStrobe;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b0; cfgAddr = a; popPulse = 1'b0; doneIn = 1'b0; clrColl = 1'b0;
    #1 d = cfgRdata;
  endtask

  task automatic runPops(input int n, input logic done, output int sels, output int first);
    sels = 0; first = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, done, 1'b0);
      if (lastSel) begin
        sels++;
        if (first == 0) first = i + 1;
      end
    end
    idle();
  endtask

  task automatic popsToSel(output int n);
    n = 0;
    do begin
      cyc(1'b1, 1'b1, 1'b0);
      n++;
    end while (!lastSel && n < 2000);
  endtask

  initial begin
    #(20 * 150000);
    failCnt++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

  initial begin
    int sels, first, n;
    logic [31:0] rd;
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R9 reset state
    #1 check(selStrobe == 1'b0, "R9 strobe idle", selStrobe, 0);
    check(collCount == 0, "R9 collCount", collCount, 0);
    readReg(2'd0, rd); check(rd == 0, "R9 interval reg", rd, 0);
    readReg(2'd1, rd); check(rd == 0, "R9 ctrl reg", rd, 0);
    runPops(MIN_IV, 1'b1, sels, first);
    check(first == MIN_IV && sels == 1, "R9 first strobe at MIN", first, MIN_IV);

    // R2 capability read, writes ignored
    readReg(2'd2, rd); check(rd == MIN_IV, "R2 capability", rd, MIN_IV);
    writeReg(2'd2, 32'd99, 1'b0);
    readReg(2'd2, rd); check(rd == MIN_IV, "R2 capability write ignored", rd, MIN_IV);

    // R1 / R2 vector table
    for (int v = 0; v < NVEC; v++) begin
      writeReg(2'd0, VECS[v].iv, 1'b0);
      runPops(int'(VECS[v].pops), 1'b1, sels, first);
      check(sels == int'(VECS[v].sels), "R1 strobe count", sels, VECS[v].sels);
      check(first == int'(VECS[v].first), "R1 first strobe position", first, VECS[v].first);
    end

    // R1 no strobe without pop
    idle(); check(lastSel == 1'b0, "R1 no strobe without pop", lastSel, 0);

    // R5 collisions, R4 one in flight
    cyc(1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    writeReg(2'd0, 32'd2, 1'b0);
    runPops(6, 1'b0, sels, first);
    check(sels == 1 && first == 2, "R4 single strobe while busy", sels, 1);
    check(collCount == 2, "R5 collisions counted", collCount, 2);
    cyc(1'b0, 1'b1, 1'b0);
    runPops(2, 1'b0, sels, first);
    check(sels == 1 && first == 2, "R4 strobe after done", first, 2);
    // R7 expiry together with done
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b0);
    check(lastSel == 1'b1, "R7 strobe with done same cycle", lastSel, 1);
    idle();
    check(collCount == 2, "R7 no collision counted", collCount, 2);

    // R6 saturation and clear
    writeReg(2'd0, 32'd1, 1'b0);
    runPops(20, 1'b0, sels, first);
    check(sels == 0, "R6 busy gives no strobe", sels, 0);
    check(collCount == 4'hF, "R6 saturate", collCount, 15);
    cyc(1'b1, 1'b0, 1'b1);
    idle();
    check(collCount == 0, "R6 clear beats collision", collCount, 0);
    cyc(1'b0, 1'b1, 1'b0);

    // R8 interval write ignores pop, reloads
    writeReg(2'd0, 32'd3, 1'b0);
    runPops(2, 1'b1, sels, first);
    writeReg(2'd0, 32'd3, 1'b1);
    check(lastSel == 1'b0, "R8 pop during write ignored", lastSel, 0);
    runPops(3, 1'b1, sels, first);
    check(first == 3, "R8 reload on write", first, 3);
    readReg(2'd0, rd); check(rd == 3, "R8 interval readback", rd, 3);
    readReg(2'd3, rd); check(rd == 0, "R8 reserved reads 0", rd, 0);

    // R3 jitter
    writeReg(2'd1, 32'd1, 1'b0);
    readReg(2'd1, rd); check(rd == 1, "R8 ctrl readback", rd, 1);
    writeReg(2'd0, 32'd4, 1'b0);
    lf = 16'hACE1;
    popsToSel(n); check(n == 4, "R3 first period unjittered", n, 4);
    popsToSel(n); check(n == 4 + int'(lf[7:0]), "R3 jitter period 1", n, 4 + lf[7:0]);
    lf = lfsrStep(lf);
    popsToSel(n); check(n == 4 + int'(lf[7:0]), "R3 jitter period 2", n, 4 + lf[7:0]);
    lf = lfsrStep(lf);
    popsToSel(n); check(n == 4 + int'(lf[7:0]), "R3 jitter period 3", n, 4 + lf[7:0]);
    idle();

    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule